// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block is the request front end of a multi-channel DMA controller. Each channel has a single-transfer request line and a burst request line from its peripheral, and software can post a request pulse for any channel. Per-channel controls decide whether a channel takes part at all and which of its request lines count. A channel can be enabled, its peripheral lines can be masked, it can be set to accept bursts only, it can be given high priority, and it can be made to stay active until its peripheral drops its request. A global master enable gates everything.

Each cycle the block picks one eligible channel. High-priority channels win over default ones, and within a level the lowest index wins. The choice is registered as a one-cycle grant pulse. The pulse carries the channel index, a flag that tells the engine whether to run a burst (2^R transfers) or a single transfer, and a flag that says the channel must be held active. The data engine answers with a busy level, and no new grant is issued while busy is high. The port vectors are `PORT_W` bits wide, but only the lower `NCH` channels are implemented.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `gnt_valid` is 0, `ch_active` is all zero and no software request is pending.
- R2: A channel can be granted only while `master_en` is 1 and its `ch_en` bit is 1. Requests of every kind on bit positions at or above `NCH` are ignored, and `gnt_idx` is always below `NCH`.
- R3: A channel whose `ch_mask` bit is 1 ignores both its `sreq` and its `breq` lines.
- R4: A channel whose `ch_burst_only` bit is 1 ignores `sreq` and is served only for `breq`. `gnt_burst` = 1 means a burst of 2^R transfers and 0 means one transfer. A `breq` gives 1, and a lone `sreq` on a channel without burst-only gives 0.
- R5: A `sw_req` pulse is latched as pending until that channel is granted. A pending software request ignores the mask and burst-only bits and is served with `gnt_burst` = 1. A new pulse that arrives in the same cycle as that channel's grant stays pending and produces a second grant.
- R6: Channels with `ch_high` = 1 are served before all default-priority channels. Within one level, the lowest index is served first.
- R7: `gnt_valid` is a registered pulse of one cycle. It never rises in two consecutive cycles, and it never follows a cycle in which `eng_busy` was 1.
- R8: `gnt_hold` equals the granted channel's `ch_wait` bit. When it is 1, the channel's `ch_active` bit is 1 from the cycle after the grant until the cycle after both its `sreq` and `breq` are low. The channel is not granted again in that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Global enable for all granting |
| eng_busy | input | 1 | Data engine is working; blocks new grants |
| sreq | input | PORT_W | Per-channel single-transfer request lines |
| breq | input | PORT_W | Per-channel burst request lines |
| sw_req | input | PORT_W | Per-channel software request pulses |
| ch_en | input | PORT_W | Channel enable bits |
| ch_mask | input | PORT_W | Peripheral request mask bits |
| ch_burst_only | input | PORT_W | Ignore single requests |
| ch_high | input | PORT_W | High-priority level bits |
| ch_wait | input | PORT_W | Hold active until request lines fall |
| gnt_valid | output | 1 | One-cycle grant pulse |
| gnt_idx | output | IDX_W | Granted channel index |
| gnt_burst | output | 1 | 1 = burst of 2^R transfers, 0 = single |
| gnt_hold | output | 1 | Granted channel is held active |
| ch_active | output | PORT_W | Channels held active after a grant |

## Verification
A software request pulse can arrive for a channel in the same cycle as the grant that consumes that channel's older pending request. The set of the pending bit and its clear then meet on one edge. The bench latches a pulse while the engine is forced busy. It then releases busy on the same falling edge that drives a second pulse on that channel, so the grant and the new pulse land on one rising edge. The scoreboard expects two grants of that channel as bursts, and it flags a missing second grant.

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int PORT_W = 32,
  parameter int NCH    = 24,
  parameter int IDX_W  = $clog2(PORT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic              eng_busy,
  input  logic [PORT_W-1:0] sreq,
  input  logic [PORT_W-1:0] breq,
  input  logic [PORT_W-1:0] sw_req,
  input  logic [PORT_W-1:0] ch_en,
  input  logic [PORT_W-1:0] ch_mask,
  input  logic [PORT_W-1:0] ch_burst_only,
  input  logic [PORT_W-1:0] ch_high,
  input  logic [PORT_W-1:0] ch_wait,
  output logic              gnt_valid,
  output logic [IDX_W-1:0]  gnt_idx,
  output logic              gnt_burst,
  output logic              gnt_hold,
  output logic [PORT_W-1:0] ch_active
);

  localparam logic [PORT_W-1:0] IMPL = {PORT_W{1'b1}} >> (PORT_W - NCH);

  logic [PORT_W-1:0] sw_pend, periph, cand, hi_cand, pick, sel_oh;
  logic [IDX_W-1:0]  sel_idx;
  logic              found, issue, sel_burst;

  assign periph  = ~ch_mask & (breq | (sreq & ~ch_burst_only));
  assign cand    = IMPL & ch_en & ~ch_active & (sw_pend | periph) & {PORT_W{master_en}};
  assign hi_cand = cand & ch_high;
  assign pick    = (|hi_cand) ? hi_cand : cand;
  assign found   = |pick;

  always_comb begin
    sel_idx = '0;
    for (int i = PORT_W - 1; i >= 0; i--)
      if (pick[i]) sel_idx = IDX_W'(i);
  end

  assign sel_oh    = PORT_W'(1) << sel_idx;
  assign issue     = found & ~eng_busy & ~gnt_valid;
  assign sel_burst = sw_pend[sel_idx] | (~ch_mask[sel_idx] & breq[sel_idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_idx   <= '0;
      gnt_burst <= 1'b0;
      gnt_hold  <= 1'b0;
      sw_pend   <= '0;
      ch_active <= '0;
    end else begin
      gnt_valid <= issue;
      if (issue) begin
        gnt_idx   <= sel_idx;
        gnt_burst <= sel_burst;
        gnt_hold  <= ch_wait[sel_idx];
      end
      sw_pend   <= (sw_pend & ~(issue ? sel_oh : '0)) | (sw_req & IMPL);
      ch_active <= (ch_active & (sreq | breq))
                 | ((issue && ch_wait[sel_idx]) ? sel_oh : '0);
    end
  end

endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
  parameter int PORT_W = 32,
  parameter int NCH    = 24,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_en,
  input logic              eng_busy,
  input logic [PORT_W-1:0] sreq,
  input logic [PORT_W-1:0] breq,
  input logic              gnt_valid,
  input logic [IDX_W-1:0]  gnt_idx,
  input logic              gnt_hold,
  input logic [PORT_W-1:0] ch_active
);

  AST_GNT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |=> !gnt_valid); // R7

  AST_NO_GNT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> ($past(!eng_busy) && $past(master_en))); // R7

  AST_GNT_IMPLEMENTED: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (int'(gnt_idx) < NCH)); // R2

  AST_HOLD_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && gnt_hold) |-> ch_active[gnt_idx]); // R8

  AST_ACTIVE_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(rst_n) |-> ((($past(ch_active) & $past(sreq | breq)) & ~ch_active) == '0)); // R8

endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.PORT_W(PORT_W), .NCH(NCH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_en(master_en), .eng_busy(eng_busy),
  .sreq(sreq), .breq(breq), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx),
  .gnt_hold(gnt_hold), .ch_active(ch_active)
);

// File: tb/test_dma_req_arbiter.sv
module test_dma_req_arbiter;
  localparam int PW = 32;
  localparam int NC = 24;
  localparam int IW = 5;

  typedef struct { int idx; bit burst; bit hold; } exp_t;

  logic clk = 0, rst_n = 0, master_en = 0, busy_force = 0;
  logic [PW-1:0] sreq = '0, breq = '0, sw_req = '0;
  logic [PW-1:0] ch_en = '0, ch_mask = '0, ch_bo = '0, ch_high = '0, ch_wait = '0;
  logic gnt_valid, gnt_burst, gnt_hold, eng_busy;
  logic [IW-1:0] gnt_idx;
  logic [PW-1:0] ch_active;

  exp_t exp_q[$];
  int n_tests = 0, n_fail = 0, gcount = 0, busy_cnt = 0;
  bit keep_lines = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;
  assign eng_busy = busy_force | (busy_cnt != 0);

  dma_req_arbiter #(.PORT_W(PW), .NCH(NC), .IDX_W(IW)) i_dma_req_arbiter (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .eng_busy(eng_busy),
    .sreq(sreq), .breq(breq), .sw_req(sw_req), .ch_en(ch_en), .ch_mask(ch_mask),
    .ch_burst_only(ch_bo), .ch_high(ch_high), .ch_wait(ch_wait),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .gnt_burst(gnt_burst),
    .gnt_hold(gnt_hold), .ch_active(ch_active));

  task automatic chk(string req, string what, longint act, longint expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Monitor and engine model: one grant pops one expected item
  always @(negedge clk) begin
    if (busy_cnt != 0) busy_cnt = busy_cnt - 1;
    if (rst_n && gnt_valid) begin
      gcount++;
      busy_cnt = 3;
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL %s unexpected grant: actual idx %0d expected none", cur_req, gnt_idx);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(cur_req, "grant idx", gnt_idx, e.idx);
        chk(cur_req, "grant burst", gnt_burst, e.burst);
        chk(cur_req, "grant hold", gnt_hold, e.hold);
      end
      if (!keep_lines) begin
        sreq[gnt_idx] = 1'b0;
        breq[gnt_idx] = 1'b0;
      end
    end
  end

  task automatic push(int idx, bit burst, bit hold);
    exp_t e;
    e.idx = idx; e.burst = burst; e.hold = hold;
    exp_q.push_back(e);
  endtask

  task automatic quiet(int n);
    repeat (n) @(negedge clk);
    chk(cur_req, "expected grants all seen (left in queue)", exp_q.size(), 0);
  endtask

  task automatic no_grant(int n);
    int g0;
    g0 = gcount;
    repeat (n) @(negedge clk);
    chk(cur_req, "grant count unchanged", gcount, g0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1", "gnt_valid after reset", gnt_valid, 0);
    chk("R1", "ch_active after reset", ch_active, 0);
    no_grant(5);

    master_en = 1;
    ch_en = '1;

    // R6: high level first, lowest index within each level
    cur_req = "R6";
    ch_high[9] = 1; ch_high[12] = 1;
    push(9, 1, 0); push(12, 0, 0); push(3, 0, 0); push(5, 0, 0);
    sreq[3] = 1; sreq[5] = 1; breq[9] = 1; sreq[12] = 1;
    quiet(40);
    ch_high = '0;

    // R3 mask, then R5 software bypasses the mask
    cur_req = "R3";
    ch_mask[2] = 1; sreq[2] = 1; breq[2] = 1;
    no_grant(10);
    cur_req = "R5";
    push(2, 1, 0);
    sw_req[2] = 1; @(negedge clk); sw_req[2] = 0;
    quiet(15);
    sreq[2] = 0; breq[2] = 0; ch_mask = '0;

    // R4 burst-only ignores single
    cur_req = "R4";
    ch_bo[4] = 1; sreq[4] = 1;
    no_grant(10);
    push(4, 1, 0);
    breq[4] = 1;
    quiet(15);
    sreq[4] = 0; ch_bo = '0;

    // R2 unimplemented channels, disabled channel, master enable
    cur_req = "R2";
    sreq[28] = 1; breq[30] = 1; sw_req[27] = 1;
    @(negedge clk); sw_req[27] = 0;
    no_grant(10);
    chk("R2", "ch_active untouched", ch_active, 0);
    sreq[28] = 0; breq[30] = 0;
    ch_en[10] = 0; sreq[10] = 1;
    no_grant(10);
    push(10, 0, 0); ch_en[10] = 1;
    quiet(15);
    master_en = 0; sreq[8] = 1;
    no_grant(10);
    push(8, 0, 0); master_en = 1;
    quiet(15);

    // R7 busy blocks grants
    cur_req = "R7";
    busy_force = 1; sreq[6] = 1;
    no_grant(10);
    push(6, 0, 0); busy_force = 0;
    quiet(15);

    // R8 wait-on-request hold
    cur_req = "R8";
    ch_wait[7] = 1; keep_lines = 1;
    push(7, 1, 1); breq[7] = 1;
    quiet(20);
    chk("R8", "ch_active[7] while line high", ch_active[7], 1);
    no_grant(10);
    breq[7] = 0;
    @(negedge clk);
    chk("R8", "ch_active[7] after lines low", ch_active[7], 0);
    no_grant(10);
    keep_lines = 0; ch_wait = '0;

    // R5 collision: new software pulse on the grant edge of its channel
    cur_req = "R5";
    busy_force = 1;
    sw_req[1] = 1; @(negedge clk); sw_req[1] = 0;
    repeat (3) @(negedge clk);
    push(1, 1, 0); push(1, 1, 0);
    busy_force = 0; sw_req[1] = 1;
    @(negedge clk); sw_req[1] = 0;
    quiet(20);
    no_grant(10);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule